// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external 128K-word by 32-bit asynchronous static RAM. The RAM is built from four byte-wide lanes. Each lane has its own active-low chip select and write enable. All lanes share one active-low output enable and one address bus. The host issues one read or one write at a time over a valid/ready handshake. A width mode selects how many lanes the access covers: one lane, a pair of lanes, or all four. A lane offset picks which lane or pair is used.

The controller turns each request into a fixed sequence of phases, each counted in clock cycles. First comes an address setup phase with every strobe high. Next comes the strobe window. Last comes a recovery phase, again with every strobe high. This order means the address only changes while no chip select is low. Read data is captured from the lanes that were selected. Lanes that were not selected come back as zero. A request whose mode and offset do not fit together is refused with an error pulse, and it touches no strobe.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `reqReady` is 1, `memCsN`, `memWeN` and `memOeN` are all ones, and `memDoe`, `rdValid` and `reqErr` are 0.
- R2: The width-mode encoding is 0 = one lane, 1 = two lanes, 2 = four lanes. In the strobe window the low bits of `memCsN` are:
  - mode 0: only bit `reqLane`;
  - mode 1: bits 1:0 for `reqLane` 0, or bits 3:2 for `reqLane` 2;
  - mode 2: all four bits.
- R3: Lane n carries data bits 8n+7..8n on `memDout`, `memDin`, `reqWdata` and `rdData`. On a read, the bits of lanes that were not selected return zero.
- R4: During a write, `memWeN` is low on exactly the selected lanes, for `WPULSE_CYC` cycles. Those cycles are the same cycles in which `memCsN` is low on those lanes. `memOeN` stays high for the whole write.
- R5: `memAddr` holds the accepted address from the cycle after acceptance until the access ends. It never changes in a cycle in which any chip select is low, or in the cycle before one.
- R6: After the accepting clock edge, all strobes stay high for `SETUP_CYC` cycles before the strobe window opens.
- R7: During a read, for `ACCESS_CYC` cycles:
  - `memCsN` is low on the selected lanes;
  - `memOeN` is low;
  - `memWeN` is all ones.
  The data seen in the last of those cycles appears on `rdData`, with `rdValid` high for exactly one cycle, in the cycle right after the window.
- R8: `memDoe` is high from the first cycle in which write enable is low until the cycle after write enable rises. At all other times it is low. It is never high while `memOeN` is low.
- R9: `reqReady` is high only while idle. It goes low at the accepting edge and returns after `RECOV_CYC` recovery cycles that follow the strobe window.
- R10: The following requests are refused: mode 3, mode 1 with an odd `reqLane`, and mode 2 with a nonzero `reqLane`. For a refused request, `reqErr` is high for the one cycle after the edge. No strobe is asserted, `reqReady` stays high, and memory is unchanged.
- R11: A request held on `reqValid` while `reqReady` is low is not taken. It is accepted at the first edge at which `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 2 | Width mode: 0 one lane, 1 two lanes, 2 four lanes |
| reqLane | input | 2 | Lane offset of the access |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 32 | Write data, lane n at bits 8n+7..8n |
| rdData | output | 32 | Read data, unselected lanes zero |
| rdValid | output | 1 | One-cycle pulse marking `rdData` valid |
| reqErr | output | 1 | One-cycle pulse for a refused request |
| memAddr | output | 17 | RAM address |
| memCsN | output | 4 | Per-lane chip selects, active low |
| memWeN | output | 4 | Per-lane write enables, active low |
| memOeN | output | 1 | Shared output enable, active low |
| memDout | output | 32 | Data toward the RAM |
| memDin | input | 32 | Data from the RAM |
| memDoe | output | 1 | Drive enable for `memDout` |

## Verification
The bench drives requests back to back, so that a new request waits on a low ready. A controller that sampled `reqValid` while busy would start a second access, and the per-cycle comparison would see extra strobes. A bus model returns a filler byte on every lane it is not reading. A design that forgot to mask the unselected lanes would return that filler instead of zero. Refused combinations are followed by a full-width read of the address they named. A refused write that still pulsed a write enable would show up as changed data. Partial writes are read back in other widths. A wrong lane map or an extra lane write enable would then corrupt neighbouring bytes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    WM_ONE  = 2'd0,
    WM_PAIR = 2'd1,
    WM_ALL  = 2'd2,
    WM_BAD  = 2'd3
  } width_mode_e;

  typedef struct packed {
    logic load;
    logic csOn;
    logic weOn;
    logic oeOn;
    logic busOn;
    logic capture;
  } strobe_t;

  function automatic logic modeLegal(logic [1:0] mode, logic [1:0] lane);
    case (width_mode_e'(mode))
      WM_ONE:  return 1'b1;
      WM_PAIR: return ~lane[0];
      WM_ALL:  return lane == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] laneMask(logic [1:0] mode, logic [1:0] lane);
    case (width_mode_e'(mode))
      WM_ONE:  return LANES'(1) << lane;
      WM_PAIR: return LANES'(3) << lane;
      WM_ALL:  return '1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 3,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqLegal,
  output logic    reqReady,
  output logic    reqErr,
  output strobe_t ctrl
);
  localparam int MAXA   = (ACCESS_CYC > WPULSE_CYC) ? ACCESS_CYC : WPULSE_CYC;
  localparam int MAXB   = (SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC;
  localparam int MAXC   = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_RECOV} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             busTail;
  logic             errQ;
  logic             lastCyc;
  logic             accept;

  assign lastCyc = (cnt == '0);
  assign accept  = (state == ST_IDLE) && reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWr    <= 1'b0;
      busTail <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      errQ    <= accept && !reqLegal;
      busTail <= (state == ST_ACT) && isWr && lastCyc;
      case (state)
        ST_IDLE: if (accept && reqLegal) begin
          state <= ST_SETUP;
          cnt   <= CNT_W'(SETUP_CYC - 1);
          isWr  <= reqWrite;
        end
        ST_SETUP: if (lastCyc) begin
          state <= ST_ACT;
          cnt   <= isWr ? CNT_W'(WPULSE_CYC - 1) : CNT_W'(ACCESS_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_ACT: if (lastCyc) begin
          state <= ST_RECOV;
          cnt   <= CNT_W'(RECOV_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (lastCyc) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.load    = accept && reqLegal;
    ctrl.csOn    = (state == ST_ACT);
    ctrl.weOn    = (state == ST_ACT) && isWr;
    ctrl.oeOn    = (state == ST_ACT) && !isWr;
    ctrl.busOn   = ((state == ST_ACT) && isWr) || busTail;
    ctrl.capture = (state == ST_ACT) && !isWr && lastCyc;
  end

  assign reqReady = (state == ST_IDLE);
  assign reqErr   = errQ;
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctrl,
  input  logic [1:0]        reqMode,
  input  logic [1:0]        reqLane,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqLegal,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memCsN,
  output logic [LANES-1:0]  memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdMasked;

  assign reqLegal = modeLegal(reqMode, reqLane);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (ctrl.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= laneMask(reqMode, reqLane);
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign rdMasked[n*LANE_W +: LANE_W] = maskQ[n] ? memDin[n*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctrl.capture;
      if (ctrl.capture) rdData <= rdMasked;
    end
  end

  assign memAddr = addrQ;
  assign memCsN  = ctrl.csOn ? ~maskQ : '1;
  assign memWeN  = ctrl.weOn ? ~maskQ : '1;
  assign memOeN  = ~ctrl.oeOn;
  assign memDout = dataQ;
  assign memDoe  = ctrl.busOn;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int SETUP_CYC  = 1,
  parameter int ACCESS_CYC = 3,
  parameter int WPULSE_CYC = 2,
  parameter int RECOV_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqMode,
  input  logic [1:0]        reqLane,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              reqErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memCsN,
  output logic [3:0]        memWeN,
  output logic              memOeN,
  output logic [31:0]       memDout,
  input  logic [31:0]       memDin,
  output logic              memDoe
);
  strobe_t ctrl;
  logic    reqLegal;

  sram_lane_fsm #(
    .SETUP_CYC(SETUP_CYC), .ACCESS_CYC(ACCESS_CYC),
    .WPULSE_CYC(WPULSE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLegal(reqLegal), .reqReady(reqReady), .reqErr(reqErr), .ctrl(ctrl)
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqMode(reqMode), .reqLane(reqLane),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLegal(reqLegal),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout), .memDin(memDin),
    .memDoe(memDoe)
  );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic              reqErr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memCsN,
  input logic [3:0]        memWeN,
  input logic              memOeN,
  input logic              memDoe
);
  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN | ~memCsN) == 4'hF); // R4
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN != 4'hF) |-> memOeN); // R4
  AST_CS_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (memCsN != 4'hF) |-> (~memCsN inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memCsN != 4'hF) |-> $stable(memAddr)); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> memOeN); // R8
  AST_RD_AFTER_OE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(!memOeN)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN == 4'hF && memWeN == 4'hF && memOeN)); // R9
  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (memCsN == 4'hF && reqReady)); // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .reqErr(reqErr), .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN),
  .memOeN(memOeN), .memDoe(memDoe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int S = 1, A = 3, W = 2, R = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqMode = 2'd0, reqLane = 2'd0;
  logic [16:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rdValid, reqErr, memOeN, memDoe;
  logic [31:0] rdData, memDout, memDin;
  logic [16:0] memAddr;
  logic [3:0]  memCsN, memWeN;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.SETUP_CYC(S), .ACCESS_CYC(A), .WPULSE_CYC(W), .RECOV_CYC(R)) i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqMode(reqMode), .reqLane(reqLane), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdData(rdData), .rdValid(rdValid), .reqErr(reqErr),
    .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDin(memDin), .memDoe(memDoe)
  );

  // external RAM model driven only by the pins
  logic [31:0] sram [int];
  always @(posedge clk)
    for (int n = 0; n < 4; n++)
      if (!memCsN[n] && !memWeN[n]) begin
        logic [31:0] w;
        w = sram.exists(memAddr) ? sram[memAddr] : 32'h0;
        w[n*8 +: 8] = memDout[n*8 +: 8];
        sram[memAddr] = w;
      end
  always @* begin
    logic [31:0] w;
    w = sram.exists(memAddr) ? sram[memAddr] : 32'h0;
    for (int n = 0; n < 4; n++)
      memDin[n*8 +: 8] = (!memCsN[n] && !memOeN && memWeN[n]) ? w[n*8 +: 8] : 8'hA5;
  end

  // behavioural reference
  logic [31:0] gold [int];
  bit          busy = 0, curWr = 0, errExp = 0;
  int          phase = 0;
  logic [3:0]  curMask = 0;
  logic [16:0] curAddr = 0;
  logic [31:0] expRd = 0;

  function automatic bit legalOf(logic [1:0] m, logic [1:0] l);
    return (m == 0) || (m == 1 && !l[0]) || (m == 2 && l == 0);
  endfunction
  function automatic logic [3:0] maskOf(logic [1:0] m, logic [1:0] l);
    if (m == 0) return 4'(1 << l);
    if (m == 1) return 4'(3 << l);
    return 4'hF;
  endfunction
  function automatic logic [31:0] bytesOf(logic [3:0] mk);
    logic [31:0] b;
    for (int n = 0; n < 4; n++) b[n*8 +: 8] = {8{mk[n]}};
    return b;
  endfunction

  always @(posedge clk) begin
    errExp = 0;
    if (!rstN) begin
      busy = 0; phase = 0;
    end else if (busy) begin
      if (phase == S + (curWr ? W : A) + R) busy = 0;
      else phase++;
    end else if (reqValid) begin
      if (legalOf(reqMode, reqLane)) begin
        logic [31:0] g, b;
        busy = 1; phase = 1;
        curWr = reqWrite; curAddr = reqAddr; curMask = maskOf(reqMode, reqLane);
        g = gold.exists(reqAddr) ? gold[reqAddr] : 32'h0;
        b = bytesOf(curMask);
        if (reqWrite) gold[reqAddr] = (g & ~b) | (reqWdata & b);
        else expRd = g & b;
      end else errExp = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    bit act, rdWin;
    int win;
    win   = curWr ? W : A;
    act   = busy && phase > S && phase <= S + win;
    rdWin = busy && !curWr && phase == S + A + 1;
    chk("R2 R6 cs", {28'h0, memCsN}, act ? {28'h0, ~curMask} : 32'hF);
    chk("R4 we", {28'h0, memWeN}, (act && curWr) ? {28'h0, ~curMask} : 32'hF);
    chk("R7 oe", {31'h0, memOeN}, {31'h0, !(act && !curWr)});
    chk("R8 doe", {31'h0, memDoe}, {31'h0, busy && curWr && phase > S && phase <= S + W + 1});
    chk("R9 R11 ready", {31'h0, reqReady}, {31'h0, !busy});
    chk("R10 err", {31'h0, reqErr}, {31'h0, errExp});
    chk("R7 rdValid", {31'h0, rdValid}, {31'h0, rdWin});
    if (busy) chk("R5 addr", {15'h0, memAddr}, {15'h0, curAddr});
    if (rdWin) chk("R3 rdData", rdData, expRd);
  end

  // R11: a new request is raised at once and held until ready
  task automatic issue(bit wr, logic [1:0] m, logic [1:0] l, logic [16:0] ad, logic [31:0] d);
    bit was;
    reqValid = 1; reqWrite = wr; reqMode = m; reqLane = l; reqAddr = ad; reqWdata = d;
    forever begin
      was = reqReady;
      @(posedge clk); @(negedge clk);
      if (was) break;
    end
    reqValid = 0;
  endtask

  task automatic idleWait();
    while (!reqReady || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'h0, reqReady}, 32'h1);
    chk("R1 strobes", {23'h0, memCsN, memWeN, memOeN}, {23'h0, 9'h1FF});
    chk("R1 flags", {29'h0, memDoe, rdValid, reqErr}, 32'h0);
    rstN = 1;
    @(negedge clk);
    issue(1, 2, 0, 17'd5, 32'h11223344);
    issue(0, 2, 0, 17'd5, 0);
    issue(1, 0, 2, 17'd5, 32'h00AA0000);          // R3 single lane
    issue(0, 1, 2, 17'd5, 0);
    issue(0, 0, 1, 17'd5, 0);
    issue(0, 1, 0, 17'd5, 0);
    issue(1, 1, 2, 17'h1FFFF, 32'hBEEF0000);
    issue(1, 0, 0, 17'h1FFFF, 32'h00000077);
    issue(0, 2, 0, 17'h1FFFF, 0);
    idleWait();
    // R10 refusals followed by a check of the memory contents
    issue(1, 3, 0, 17'd5, 32'h0);
    issue(1, 1, 1, 17'd5, 32'h0);
    issue(1, 2, 2, 17'd5, 32'h0);
    chk("R10 ready kept", {31'h0, reqReady}, 32'h1);
    issue(0, 2, 0, 17'd5, 0);
    idleWait();
    chk("R10 unchanged", rdData, 32'h11AA3344);
    for (int i = 0; i < 60; i++)
      issue($urandom_range(0, 1), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            17'($urandom_range(0, 7)), $urandom);
    idleWait();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule